// File: doc/BRIEF.md
# Time Interval Error Calculator

This block takes a stream of measured clock-edge timestamps, counted in timebase ticks, and reports for every accepted edge how far that edge sits from where an ideal clock would have placed it. The ideal clock starts exactly on the first edge accepted after an arm pulse. It then advances by a programmed nominal period that carries 16 fractional bits, so that periods which are not whole numbers of ticks do not build up rounding drift.

Each result is a signed error in ticks, sent out together with the edge's position in the block. The block also keeps the smallest and largest error seen since the last arm. That spread is the figure used to judge long-term wander. If the programmed period does not match the real one, the error ramps steadily from edge to edge. The block passes that ramp through as it is and does not hide it. An arm that arrives before a deliberate phase step on the measured clock therefore captures the whole settling curve.

Top module: `tie_calc`

## Requirements
- R1: After reset, errValid is 0, errMin and errMax are 0 and errOvf is 0. Timestamps offered before the first arm pulse produce no output.
- R2: An arm pulse starts a block. A timestamp offered in the same cycle as armIn is ignored. The first timestamp accepted after the arm produces error 0 with index 0.
- R3: For the edge with index n, the error is ts minus the integer part of (t0·2^16 + n·P) / 2^16. Here t0 is the first accepted timestamp and P is nomPeriod, an unsigned value with 16 integer bits above 16 fractional bits.
- R4: The sign follows the edge: an edge later than its ideal position gives a positive error, and an earlier edge gives a negative error. errData is two's complement.
- R5: A mismatch between P and the real period shows as an error that changes by the same amount on every edge, with no correction applied.
- R6: An error beyond the signed range of errData is clamped to the largest or smallest value, and errOvf is set. errOvf stays set until the next arm pulse.
- R7: errValid pulses for exactly one cycle, in the cycle after each accepted timestamp. errIndex increases by one for each edge in a block.
- R8: errMin and errMax hold the extremes of all errors in the current block, including the first zero. Both are cleared to 0 by an arm pulse.
- R9: nomPeriod is captured on the arm pulse. Changing it during a block has no effect on that block.
- R10: An arm pulse during a running block restarts it. The next accepted edge again gives error 0 with index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| armIn | input | 1 | Block start pulse |
| tsValid | input | 1 | Timestamp present this cycle |
| tsData | input | TS_W (32) | Edge timestamp in ticks |
| nomPeriod | input | PER_W (32) | Ideal period, 16.16 fixed point |
| errValid | output | 1 | Error result strobe |
| errData | output | ERR_W (16) | Signed time interval error |
| errIndex | output | IDX_W (16) | Edge index within block |
| errMin | output | ERR_W (16) | Smallest error of block |
| errMax | output | ERR_W (16) | Largest error of block |
| errOvf | output | 1 | Sticky saturation flag |

## Verification
The hardest condition to reach is saturation in both directions within one block, followed by ordinary edges. The stimulus uses a large first timestamp so that a later edge can lie far below its ideal time without its timestamp going negative. It then offers one edge far late, one far early, and one on time. The bench checks that the clamped extremes stay in errMin and errMax, and that errOvf stays set until the next arm. A fractional period of 100.25 ticks against whole-tick edges produces a slow negative ramp, which tests the fixed-point accumulation and the floor step.

// File: rtl/tie_pkg.sv
package tie_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIRST = 2'd1,
    ST_RUN   = 2'd2
  } tieState_t;

  typedef struct packed {
    logic clearStats;
    logic loadFirst;
    logic step;
  } tieStrobe_t;

endpackage

// File: rtl/tie_ctrl.sv
module tie_ctrl
  import tie_pkg::*;
#(
  parameter int IDX_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             armIn,
  input  logic             tsValid,
  output tieStrobe_t       strb,
  output logic [IDX_W-1:0] edgeIdx
);

  tieState_t        state, stateNext;
  logic [IDX_W-1:0] nextIdx;

  always_comb begin
    stateNext       = state;
    strb            = '0;
    strb.clearStats = armIn;
    if (armIn) begin
      stateNext = ST_FIRST;
    end else if (tsValid) begin
      case (state)
        ST_FIRST: begin
          strb.loadFirst = 1'b1;
          stateNext      = ST_RUN;
        end
        ST_RUN:  strb.step = 1'b1;
        default: stateNext = state;
      endcase
    end
  end

  assign edgeIdx = strb.loadFirst ? '0 : nextIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      nextIdx <= '0;
    end else begin
      state <= stateNext;
      if (strb.loadFirst)  nextIdx <= IDX_W'(1);
      else if (strb.step)  nextIdx <= nextIdx + IDX_W'(1);
    end
  end

endmodule

// File: rtl/tie_datapath.sv
module tie_datapath
  import tie_pkg::*;
#(
  parameter int TS_W   = 32,
  parameter int FRAC_W = 16,
  parameter int PER_W  = 32,
  parameter int ERR_W  = 16,
  parameter int IDX_W  = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  tieStrobe_t              strb,
  input  logic [IDX_W-1:0]        edgeIdx,
  input  logic [TS_W-1:0]         tsData,
  input  logic [PER_W-1:0]        nomPeriod,
  output logic                    errValid,
  output logic signed [ERR_W-1:0] errData,
  output logic [IDX_W-1:0]        errIndex,
  output logic signed [ERR_W-1:0] errMin,
  output logic signed [ERR_W-1:0] errMax,
  output logic                    errOvf
);

  localparam int ACC_W = TS_W + FRAC_W;
  localparam logic signed [TS_W-1:0] SAT_HI = TS_W'((1 << (ERR_W-1)) - 1);
  localparam logic signed [TS_W-1:0] SAT_LO = -TS_W'(1 << (ERR_W-1));

  logic [ACC_W-1:0]        idealAcc;
  logic [ACC_W-1:0]        idealNext;
  logic [PER_W-1:0]        perHeld;
  logic [TS_W-1:0]         idealInt;
  logic signed [TS_W-1:0]  rawDiff;
  logic signed [ERR_W-1:0] satErr;
  logic                    satHit;
  logic                    edgeEvt;

  assign edgeEvt = strb.loadFirst | strb.step;

  always_comb begin
    if (strb.loadFirst) idealNext = {tsData, {FRAC_W{1'b0}}};
    else                idealNext = idealAcc + ACC_W'(perHeld);
  end

  assign idealInt = idealNext[ACC_W-1:FRAC_W];
  assign rawDiff  = $signed(tsData - idealInt);

  always_comb begin
    satHit = 1'b0;
    if (rawDiff > SAT_HI) begin
      satErr = SAT_HI[ERR_W-1:0];
      satHit = 1'b1;
    end else if (rawDiff < SAT_LO) begin
      satErr = SAT_LO[ERR_W-1:0];
      satHit = 1'b1;
    end else begin
      satErr = rawDiff[ERR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idealAcc <= '0;
      perHeld  <= '0;
      errValid <= 1'b0;
      errData  <= '0;
      errIndex <= '0;
      errMin   <= '0;
      errMax   <= '0;
      errOvf   <= 1'b0;
    end else begin
      errValid <= edgeEvt;
      if (strb.clearStats) begin
        perHeld <= nomPeriod;
        errMin  <= '0;
        errMax  <= '0;
        errOvf  <= 1'b0;
      end
      if (edgeEvt) begin
        idealAcc <= idealNext;
        errData  <= satErr;
        errIndex <= edgeIdx;
        if (satErr < errMin) errMin <= satErr;
        if (satErr > errMax) errMax <= satErr;
        if (satHit)          errOvf <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/tie_calc.sv
module tie_calc
  import tie_pkg::*;
#(
  parameter int TS_W   = 32,
  parameter int FRAC_W = 16,
  parameter int PER_W  = 32,
  parameter int ERR_W  = 16,
  parameter int IDX_W  = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    armIn,
  input  logic                    tsValid,
  input  logic [TS_W-1:0]         tsData,
  input  logic [PER_W-1:0]        nomPeriod,
  output logic                    errValid,
  output logic signed [ERR_W-1:0] errData,
  output logic [IDX_W-1:0]        errIndex,
  output logic signed [ERR_W-1:0] errMin,
  output logic signed [ERR_W-1:0] errMax,
  output logic                    errOvf
);

  tieStrobe_t       strb;
  logic [IDX_W-1:0] edgeIdx;

  tie_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .armIn   (armIn),
    .tsValid (tsValid),
    .strb    (strb),
    .edgeIdx (edgeIdx)
  );

  tie_datapath #(
    .TS_W   (TS_W),
    .FRAC_W (FRAC_W),
    .PER_W  (PER_W),
    .ERR_W  (ERR_W),
    .IDX_W  (IDX_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .edgeIdx   (edgeIdx),
    .tsData    (tsData),
    .nomPeriod (nomPeriod),
    .errValid  (errValid),
    .errData   (errData),
    .errIndex  (errIndex),
    .errMin    (errMin),
    .errMax    (errMax),
    .errOvf    (errOvf)
  );

endmodule

// File: rtl/tie_calc_chk.sv
module tie_calc_chk #(
  parameter int ERR_W = 16,
  parameter int IDX_W = 16
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    armIn,
  input logic                    tsValid,
  input logic                    errValid,
  input logic signed [ERR_W-1:0] errData,
  input logic [IDX_W-1:0]        errIndex,
  input logic signed [ERR_W-1:0] errMin,
  input logic signed [ERR_W-1:0] errMax,
  input logic                    errOvf
);

  logic everArmed;
  logic firstPending;
  logic pastOk;
  logic [IDX_W-1:0] lastIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      everArmed    <= 1'b0;
      firstPending <= 1'b0;
      pastOk       <= 1'b0;
      lastIdx      <= '0;
    end else begin
      pastOk <= 1'b1;
      if (armIn) begin
        everArmed    <= 1'b1;
        firstPending <= 1'b1;
      end else if (errValid) begin
        firstPending <= 1'b0;
      end
      if (errValid) lastIdx <= errIndex;
    end
  end

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    errValid |-> everArmed); // R1

  AST_FIRST_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (errValid && firstPending) |-> (errData == '0 && errIndex == '0)); // R2

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && $fell(errOvf)) |-> $past(armIn)); // R6

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && errValid) |-> ($past(tsValid) && !$past(armIn))); // R7

  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (errValid && !firstPending) |-> errIndex == lastIdx + IDX_W'(1)); // R7

  AST_MIN_MAX_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    errMin <= errMax); // R8

  AST_ERR_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    errValid |-> (errData >= errMin && errData <= errMax)); // R8

endmodule

bind tie_calc tie_calc_chk #(.ERR_W(ERR_W), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .armIn    (armIn),
  .tsValid  (tsValid),
  .errValid (errValid),
  .errData  (errData),
  .errIndex (errIndex),
  .errMin   (errMin),
  .errMax   (errMax),
  .errOvf   (errOvf)
);

// File: tb/tie_calc_tb.sv
module tie_calc_tb;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               armIn = 1'b0;
  logic               tsValid = 1'b0;
  logic [31:0]        tsData = '0;
  logic [31:0]        nomPeriod = '0;
  logic               errValid;
  logic signed [15:0] errData;
  logic [15:0]        errIndex;
  logic signed [15:0] errMin;
  logic signed [15:0] errMax;
  logic               errOvf;

  int total = 0;
  int bad = 0;

  longint mT0, mN, mPer, mMin, mMax;
  bit     mFirst, mOvf;

  always #2 clk = ~clk;

  tie_calc u_dut (
    .clk(clk), .rstN(rstN), .armIn(armIn), .tsValid(tsValid),
    .tsData(tsData), .nomPeriod(nomPeriod), .errValid(errValid),
    .errData(errData), .errIndex(errIndex), .errMin(errMin),
    .errMax(errMax), .errOvf(errOvf)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic arm(input longint per);
    @(negedge clk);
    nomPeriod = 32'(per);
    armIn = 1'b1;
    @(negedge clk);
    armIn = 1'b0;
    mPer = per; mFirst = 1'b1; mMin = 0; mMax = 0; mOvf = 1'b0; mN = 0;
  endtask

  task automatic edgeAt(input string tag, input longint ts);
    longint e;
    @(negedge clk);
    tsValid = 1'b1;
    tsData  = 32'(ts);
    @(posedge clk);
    #1;
    tsValid = 1'b0;
    if (mFirst) begin
      mT0 = ts; mN = 0; e = 0; mFirst = 1'b0;
    end else begin
      mN = mN + 1;
      e = ts - (((mT0 <<< 16) + mN * mPer) >>> 16);
    end
    if (e > 32767)  begin e = 32767;  mOvf = 1'b1; end
    if (e < -32768) begin e = -32768; mOvf = 1'b1; end
    if (e < mMin) mMin = e;
    if (e > mMax) mMax = e;
    check({tag, " valid"}, longint'(errValid), 1);
    check({tag, " err"},   longint'(errData), e);
    check({tag, " idx"},   longint'(errIndex), mN);
    check({tag, " min"},   longint'(errMin), mMin);
    check({tag, " max"},   longint'(errMax), mMax);
    check({tag, " ovf"},   longint'(errOvf), longint'(mOvf));
    @(posedge clk);
    #1;
    check({tag, " pulse"}, longint'(errValid), 0);
  endtask

  task automatic tReset();
    check("R1 rst valid", longint'(errValid), 0);
    check("R1 rst min",   longint'(errMin), 0);
    check("R1 rst max",   longint'(errMax), 0);
    check("R1 rst ovf",   longint'(errOvf), 0);
    @(negedge clk); tsValid = 1'b1; tsData = 32'd500;
    @(posedge clk); #1; tsValid = 1'b0;
    check("R1 idle edge", longint'(errValid), 0);
    @(posedge clk); #1;
    check("R1 idle edge late", longint'(errValid), 0);
  endtask

  task automatic tArmSameCycle();
    @(negedge clk);
    nomPeriod = 32'(100 <<< 16); armIn = 1'b1; tsValid = 1'b1; tsData = 32'd777;
    @(posedge clk); #1;
    check("R2 arm-cycle edge ignored", longint'(errValid), 0);
    @(negedge clk); armIn = 1'b0; tsValid = 1'b0;
    mPer = 100 <<< 16; mFirst = 1'b1; mMin = 0; mMax = 0; mOvf = 1'b0;
    edgeAt("R2 first", 2000);
    edgeAt("R3 exact", 2100);
  endtask

  task automatic tFractional();
    arm(100 * 65536 + 16384);
    for (int i = 1; i <= 8; i++) edgeAt("R3 frac", 5000 + 100 * i - 100);
  endtask

  task automatic tSign();
    arm(100 <<< 16);
    edgeAt("R4 first", 10000);
    edgeAt("R4 lag", 10107);
    edgeAt("R4 lead", 10195);
  endtask

  task automatic tMismatch();
    arm(100 <<< 16);
    for (int i = 0; i < 6; i++) edgeAt("R5 ramp", 20000 + 103 * i);
  endtask

  task automatic tSaturation();
    arm(100 <<< 16);
    edgeAt("R6 first", 100000);
    edgeAt("R6 hi", 100100 + 40000);
    edgeAt("R6 lo", 100200 - 40000);
    edgeAt("R6 sticky", 100300);
    arm(100 <<< 16);
    check("R6 arm clears ovf", longint'(errOvf), 0);
    check("R8 arm clears min", longint'(errMin), 0);
    check("R8 arm clears max", longint'(errMax), 0);
  endtask

  task automatic tPeriodHeld();
    arm(50 <<< 16);
    edgeAt("R9 first", 30000);
    @(negedge clk); nomPeriod = 32'(80 <<< 16);
    edgeAt("R9 held", 30050);
    edgeAt("R9 held2", 30100);
  endtask

  task automatic tRearm();
    arm(100 <<< 16);
    edgeAt("R10 a", 40000);
    edgeAt("R10 b", 40120);
    arm(100 <<< 16);
    edgeAt("R10 restart", 50033);
    edgeAt("R10 next", 50130);
    edgeAt("R8 extreme", 50210);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
      begin
        repeat (3) @(posedge clk);
        @(negedge clk); rstN = 1'b1;
        @(posedge clk); #1;
        tReset();
        tArmSameCycle();
        tFractional();
        tSign();
        tMismatch();
        tSaturation();
        tPeriodHeld();
        tRearm();
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule